// File: doc/BRIEF.md
# Chroma 4:1:1 Output Formatter

This block sits at the digital back end of a video capture path. Each pixel clock it takes one 8-bit luma sample and one offset-binary U and V chroma sample. On request it cores the chroma: a code that lies within a narrow band around mid-scale (128) is snapped to exactly 128. It then converts chroma to two's complement by inverting the most significant bit. Each converted U and V byte goes out over four consecutive clocks on a 2-bit lane per component, most significant pair first, which makes the output stream 4:1:1.

A group-start strobe marks the pixel at which a new chroma pair is captured and the slice sequence restarts. Luma is passed through as plain binary with a selectable delay of zero to three clocks, so that it can be lined up with the chroma slices downstream. A phase output gives the index of the slice currently on the lanes.

Top module: `chroma411_fmt`

## Requirements
- R1: While reset is asserted and on the first cycle after it, lane_phase is 0 and both lanes are 0. With y_dly at 1 or more, y_out is 0 during reset.
- R2: y_out equals y_in from y_dly clock cycles earlier, where y_dly is the delay in clocks (0 to 3). With a value of 0, y_out follows y_in in the same cycle.
- R3: A clock edge with grp_start high captures u_in and v_in, and sets lane_phase to 0 for the following cycle.
- R4: When grp_start is low, lane_phase advances by one on every clock and wraps from 3 to 0. At phase k each lane carries bits [7-2k:6-2k] of its held byte: bits 7:6 at phase 0, then 5:4, 3:2 and 1:0.
- R5: With core_sel = 00, coring is off and the transmitted byte is the input code with bit 7 inverted. For example, 0x80 is sent as 0x00 and 0xFF as 0x7F.
- R6: With core_sel = 01, input codes 127 to 129 are sent as 0x00. Codes 126 and 130 are only converted.
- R7: With core_sel = 10, input codes 128 and 129 are sent as 0x00. Codes 127 and 130 are only converted.
- R8: With core_sel = 11, input codes 127 to 130 are sent as 0x00. Codes 126 and 131 are only converted.
- R9: Changes on u_in and v_in while grp_start is low have no effect on the lanes. The held bytes repeat on every pass of four slices until the next group start.
- R10: A group start that arrives before a four-slice group has finished ends that group at once. The next cycle shows slice 0 of the newly captured bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_start | input | 1 | Capture chroma and restart the slice sequence |
| y_in | input | 8 | Luma sample, binary |
| u_in | input | 8 | U sample, offset binary |
| v_in | input | 8 | V sample, offset binary |
| core_sel | input | 2 | Coring band: 00 off, 01 +1/-1, 10 +1/-0, 11 +2/-1 |
| y_dly | input | 2 | Luma delay in clocks, 0 to 3 |
| y_out | output | 8 | Delayed luma |
| u_lane | output | 2 | Current 2-bit slice of U (two's complement) |
| v_lane | output | 2 | Current 2-bit slice of V (two's complement) |
| lane_phase | output | 2 | Index of the slice currently on the lanes |

## Verification
Two situations are hard to reach from the ports. The first is a group start that lands in the middle of a group. The stimulus raises grp_start right after the second slice and then checks that slice 0 of the new bytes appears at once. The second is proof that the held bytes ignore the inputs. While grp_start is low, every collection pass inverts u_in and v_in, and a second pass of four slices must rebuild the original bytes. The coring bands are probed at the codes on both sides of each edge for every mode.

// File: rtl/c411_pkg.sv
package c411_pkg;

    localparam int C411_DW    = 8;
    localparam int C411_LW    = 2;
    localparam int C411_MAXD  = 3;

    typedef enum logic [1:0] {
        CORE_OFF  = 2'b00,
        CORE_PM1  = 2'b01,
        CORE_P1   = 2'b10,
        CORE_P2M1 = 2'b11
    } core_mode_e;

    typedef struct packed {
        logic [1:0] up;
        logic [1:0] dn;
        logic       en;
    } core_band_t;

    function automatic core_band_t band_of(input core_mode_e m);
        core_band_t b;
        case (m)
            CORE_PM1:  b = '{up: 2'd1, dn: 2'd1, en: 1'b1};
            CORE_P1:   b = '{up: 2'd1, dn: 2'd0, en: 1'b1};
            CORE_P2M1: b = '{up: 2'd2, dn: 2'd1, en: 1'b1};
            default:   b = '{up: 2'd0, dn: 2'd0, en: 1'b0};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/chroma_corer.sv
module chroma_corer
    import c411_pkg::*;
#(
    parameter int DW = C411_DW
) (
    input  logic [DW-1:0] code_in,
    input  core_mode_e    mode,
    output logic [DW-1:0] tc_out
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    core_band_t     band;
    logic [DW-1:0]  lo_lim;
    logic [DW-1:0]  hi_lim;
    logic           in_band;
    logic [DW-1:0]  cored;

    always_comb begin
        band    = band_of(mode);
        lo_lim  = MID - DW'(band.dn);
        hi_lim  = MID + DW'(band.up);
        in_band = band.en && (code_in >= lo_lim) && (code_in <= hi_lim);
        cored   = in_band ? MID : code_in;
        tc_out  = cored ^ MID;
    end
endmodule

// File: rtl/slice_serializer.sv
module slice_serializer #(
    parameter int DW = 8,
    parameter int LW = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [DW-1:0]                din_u,
    input  logic [DW-1:0]                din_v,
    output logic [LW-1:0]                lane_u,
    output logic [LW-1:0]                lane_v,
    output logic [$clog2(DW/LW)-1:0]     phase
);
    localparam int NSL  = DW / LW;
    localparam int PH_W = $clog2(NSL);
    localparam logic [PH_W-1:0] LAST = PH_W'(NSL - 1);

    logic [DW-1:0] hold_u;
    logic [DW-1:0] hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_u <= '0;
            hold_v <= '0;
            phase  <= '0;
        end else if (load) begin
            hold_u <= din_u;
            hold_v <= din_v;
            phase  <= '0;
        end else begin
            phase  <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    always_comb begin
        lane_u = hold_u[DW-1 - LW*phase -: LW];
        lane_v = hold_v[DW-1 - LW*phase -: LW];
    end
endmodule

// File: rtl/luma_delay.sv
module luma_delay #(
    parameter int DW   = 8,
    parameter int MAXD = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DW-1:0]               din,
    input  logic [$clog2(MAXD+1)-1:0]   sel,
    output logic [DW-1:0]               dout
);
    logic [DW-1:0] tap [0:MAXD];

    assign tap[0] = din;

    for (genvar s = 1; s <= MAXD; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[s] <= '0;
            else     tap[s] <= tap[s-1];
        end
    end

    always_comb begin
        if (int'(sel) > MAXD) dout = tap[MAXD];
        else                  dout = tap[sel];
    end
endmodule

// File: rtl/chroma411_fmt.sv
module chroma411_fmt
    import c411_pkg::*;
#(
    parameter int DW   = C411_DW,
    parameter int LW   = C411_LW,
    parameter int MAXD = C411_MAXD
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       grp_start,
    input  logic [DW-1:0]              y_in,
    input  logic [DW-1:0]              u_in,
    input  logic [DW-1:0]              v_in,
    input  logic [1:0]                 core_sel,
    input  logic [$clog2(MAXD+1)-1:0]  y_dly,
    output logic [DW-1:0]              y_out,
    output logic [LW-1:0]              u_lane,
    output logic [LW-1:0]              v_lane,
    output logic [$clog2(DW/LW)-1:0]   lane_phase
);
    localparam int NCH = 2;

    logic [DW-1:0] raw [NCH];
    logic [DW-1:0] tc  [NCH];

    assign raw[0] = u_in;
    assign raw[1] = v_in;

    for (genvar c = 0; c < NCH; c++) begin : g_core
        chroma_corer #(.DW(DW)) u_core (
            .code_in (raw[c]),
            .mode    (core_mode_e'(core_sel)),
            .tc_out  (tc[c])
        );
    end

    slice_serializer #(.DW(DW), .LW(LW)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (grp_start),
        .din_u  (tc[0]),
        .din_v  (tc[1]),
        .lane_u (u_lane),
        .lane_v (v_lane),
        .phase  (lane_phase)
    );

    luma_delay #(.DW(DW), .MAXD(MAXD)) u_ydly (
        .clk  (clk),
        .rst  (rst),
        .din  (y_in),
        .sel  (y_dly),
        .dout (y_out)
    );
endmodule

// File: rtl/chroma411_chk.sv
module chroma411_chk (
    input logic       clk,
    input logic       rst,
    input logic       grp_start,
    input logic [7:0] y_in,
    input logic [7:0] u_in,
    input logic [7:0] v_in,
    input logic [1:0] core_sel,
    input logic [1:0] y_dly,
    input logic [7:0] y_out,
    input logic [1:0] u_lane,
    input logic [1:0] v_lane,
    input logic [1:0] lane_phase
);
    logic [1:0] live;

    always_ff @(posedge clk) begin
        if (rst)              live <= 2'd0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    assert_reset_phase_R1: assert property (@(posedge clk)
        $past(rst) |-> (lane_phase == 2'd0 && u_lane == 2'd0 && v_lane == 2'd0));

    assert_ydly_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (y_dly == 2'd0) |-> (y_out == y_in));

    assert_ydly_one_R2: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd1 && y_dly == 2'd1) |-> (y_out == $past(y_in)));

    assert_ydly_two_R2: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd2 && y_dly == 2'd2) |-> (y_out == $past(y_in, 2)));

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        grp_start |=> (lane_phase == 2'd0));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
        !grp_start |=> (lane_phase == $past(lane_phase) + 2'd1));

    assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
        (grp_start && core_sel == 2'b00) |=>
            (u_lane == {~$past(u_in[7]), $past(u_in[6])} &&
             v_lane == {~$past(v_in[7]), $past(v_in[6])}));

    assert_core_wide_R8: assert property (@(posedge clk) disable iff (rst)
        (grp_start && core_sel == 2'b11 && u_in >= 8'd127 && u_in <= 8'd130) |=>
            (u_lane == 2'd0));
endmodule

bind chroma411_fmt chroma411_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .grp_start  (grp_start),
    .y_in       (y_in),
    .u_in       (u_in),
    .v_in       (v_in),
    .core_sel   (core_sel),
    .y_dly      (y_dly),
    .y_out      (y_out),
    .u_lane     (u_lane),
    .v_lane     (v_lane),
    .lane_phase (lane_phase)
);

// File: tb/test_chroma411_fmt.sv
module test_chroma411_fmt;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       grp_start = 1'b0;
    logic [7:0] y_in = '0, u_in = '0, v_in = '0;
    logic [1:0] core_sel = '0, y_dly = '0;
    logic [7:0] y_out;
    logic [1:0] u_lane, v_lane, lane_phase;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    chroma411_fmt i_chroma411_fmt (
        .clk(clk), .rst(rst), .grp_start(grp_start),
        .y_in(y_in), .u_in(u_in), .v_in(v_in),
        .core_sel(core_sel), .y_dly(y_dly),
        .y_out(y_out), .u_lane(u_lane), .v_lane(v_lane),
        .lane_phase(lane_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] c, input logic [1:0] m);
        int lo, hi;
        logic [7:0] cored;
        case (m)
            2'b01:   begin lo = 127; hi = 129; end
            2'b10:   begin lo = 128; hi = 129; end
            2'b11:   begin lo = 127; hi = 130; end
            default: begin lo = 1;   hi = 0;   end
        endcase
        cored = (int'(c) >= lo && int'(c) <= hi) ? 8'd128 : c;
        return cored ^ 8'h80;
    endfunction

    task automatic load(input logic [7:0] u, input logic [7:0] v, input logic [1:0] m);
        @(negedge clk);
        grp_start = 1'b1; u_in = u; v_in = v; core_sel = m;
    endtask

    task automatic collect(input logic [7:0] eu, input logic [7:0] ev, input string req);
        logic [7:0] gu = '0, gv = '0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                grp_start = 1'b0; u_in = ~u_in; v_in = ~v_in;
            end
            chk(lane_phase == 2'(k), "R4 phase", lane_phase, k);
            gu = {gu[5:0], u_lane};
            gv = {gv[5:0], v_lane};
        end
        chk(gu == eu, {req, " U byte"}, gu, eu);
        chk(gv == ev, {req, " V byte"}, gv, ev);
    endtask

    task automatic t_reset();
        y_dly = 2'd1; y_in = 8'hA7; u_in = 8'h3C; v_in = 8'hC3;
        repeat (3) @(negedge clk);
        chk(y_out == 8'h00, "R1 y_out", y_out, 0);
        chk(lane_phase == 2'd0, "R1 phase", lane_phase, 0);
        chk(u_lane == 2'd0 && v_lane == 2'd0, "R1 lanes", {u_lane, v_lane}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(lane_phase == 2'd1, "R4 free-run after R1", lane_phase, 1);
    endtask

    task automatic t_luma(input int d);
        logic [7:0] hist [8];
        y_dly = 2'(d);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            hist[i] = 8'(i * 37 + d * 11 + 5);
            y_in = hist[i];
            #1;
            if (i >= d) chk(y_out == hist[i-d], "R2 luma delay", y_out, hist[i-d]);
        end
    endtask

    task automatic t_group(input logic [7:0] u, input logic [7:0] v,
                           input logic [1:0] m, input string req);
        load(u, v, m);
        collect(model(u, m), model(v, m), req);
    endtask

    task automatic t_hold();
        load(8'h1B, 8'hE4, 2'b00);
        collect(8'h9B, 8'h64, "R9 first pass");
        collect(8'h9B, 8'h64, "R9 repeat pass");
    endtask

    task automatic t_restart();
        load(8'h00, 8'hFF, 2'b00);
        @(negedge clk);
        grp_start = 1'b0;
        chk(lane_phase == 2'd0, "R10 slice0", lane_phase, 0);
        @(negedge clk);
        chk(lane_phase == 2'd1, "R10 slice1", lane_phase, 1);
        grp_start = 1'b1; u_in = 8'hC6; v_in = 8'h39;
        collect(8'h46, 8'hB9, "R10 early restart");
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        for (int d = 0; d < 4; d++) t_luma(d);
        t_group(8'h80, 8'hFF, 2'b00, "R5 R3 mid/top");
        t_group(8'h00, 8'h5A, 2'b00, "R5 R3 zero/pattern");
        t_group(8'd127, 8'd129, 2'b01, "R6 band");
        t_group(8'd126, 8'd130, 2'b01, "R6 outside");
        t_group(8'd128, 8'd129, 2'b10, "R7 band");
        t_group(8'd127, 8'd130, 2'b10, "R7 outside");
        t_group(8'd127, 8'd130, 2'b11, "R8 band");
        t_group(8'd126, 8'd131, 2'b11, "R8 outside");
        t_hold();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule